// File: doc/BRIEF.md
# Delay-Matched ADC Pre-Trigger Channel

This block is one channel of a programmable delay trigger unit. It watches a shared 16-bit counter that runs freely elsewhere in the chip. It owns up to eight pre-trigger slots, and each slot holds a delay value. A slot fires when its enable is high and the counter equals its delay. A fired slot can fire again only after the next counter cycle begins.

The fired slots compete for one ADC. The lowest-numbered fired slot wins and sends a one-cycle trigger pulse to the ADC, together with its index. This happens only when the ADC reports idle and no trigger was sent in the cycle before. Every fired slot that is refused sets a sticky sequence-error flag. Every fired slot, whether accepted or refused, sets a sticky match flag. Software clears a flag by writing 0 to it.

Delay values are written into shadow copies. The `cyc_wrap` strobe marks the start of a counter cycle. On that strobe the shadow copies move into the active set, and every slot is armed again. A delay read always returns the active value.

Top module: `pretrig_channel`

## Requirements
- R1: When slot m is armed, its bit of `pt_en` is high and `cnt_val` equals active delay m, `pt_fire[m]` is high in the following cycle.
- R2: A slot fires at most once between two `cyc_wrap` strobes; `cyc_wrap` re-arms every slot. A slot that returns to its delay value without an intervening strobe does not fire.
- R3: A slot whose `pt_en` bit is low does not fire and sets no flag.
- R4: In the cycle after a match, `adc_trig` pulses high for one cycle and `trig_idx` holds the lowest fired slot index. This happens only when `adc_busy` was low and `adc_trig` was low in the match cycle. `adc_trig` is never high in two consecutive cycles.
- R5: Every fired slot that is not accepted sets its sequence-error flag. The flag for slot m is status bit m, at address 0.
- R6: Every fired slot m sets its match flag, which is status bit 16+m.
- R7: A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. If a flag is set by hardware and cleared by software in the same cycle, it ends up set.
- R8: A write to address 1+m stores data bits 15:0 in the shadow delay of slot m. A read of that address returns the active delay in bits 15:0. `cyc_wrap` copies the shadow delay into the active delay.
- R9: The following read as 0: status bits 31:24 and 15:8, status bits for slots NPT and above, delay bits 31:16, and any address above NPT. After reset every flag and delay is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cyc_wrap | input | 1 | Counter-cycle start: loads active delays and re-arms slots |
| pt_en | input | NPT | Per-slot fire enables |
| adc_busy | input | 1 | ADC conversion in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0 status, 1+m delay of slot m |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pt_fire | output | NPT | Registered per-slot fire pulses |
| adc_trig | output | 1 | One-cycle trigger to the ADC |
| trig_idx | output | 3 | Index of the slot behind the last trigger |

## Verification
The assertions assume that reset is applied once at the start and never again, so that the flags can only fall through a status write. They also assume that `adc_busy` is an ordinary level driven by the ADC with no link to the outputs of this block. The bench keeps to these assumptions: it drives `adc_busy` as one contiguous window per sweep and never asserts reset after start-up. It moves the counter upward one value per clock, and it strobes `cyc_wrap` only at a counter value that no programmed delay uses.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;

    localparam int CNT_W   = 16;
    localparam int REG_W   = 32;
    localparam int MAX_PT  = 8;
    localparam int IDX_W   = 3;
    localparam int ADDR_W  = 4;
    localparam int CF_LSB  = 16;
    localparam int ERR_LSB = 0;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic [MAX_PT-1:0] accept;
        logic [MAX_PT-1:0] err_set;
        pick_t             pick;
    } arb_t;

    function automatic pick_t first_set(input logic [MAX_PT-1:0] v);
        pick_t r;
        r = '0;
        for (int i = MAX_PT - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [MAX_PT-1:0] idx_to_onehot(input logic [IDX_W-1:0] i);
        return MAX_PT'(1) << i;
    endfunction

endpackage

// File: rtl/ptc_delay_slot.sv
module ptc_delay_slot
    import pretrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             cyc_wrap,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             en,
    output logic             match,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             armed_q;

    assign match  = armed_q & en & (cnt_val == active_q);
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            armed_q  <= 1'b1;
        end else begin
            if (wr_sel) begin
                shadow_q <= wr_val;
            end
            if (cyc_wrap) begin
                active_q <= shadow_q;
                armed_q  <= 1'b1;
            end else if (match) begin
                armed_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ptc_arbiter.sv
module ptc_arbiter
    import pretrig_pkg::*;
#(
    parameter int NPT = 4
) (
    input  logic [NPT-1:0] match,
    input  logic           busy,
    input  logic           inflight,
    output arb_t           res
);

    logic [MAX_PT-1:0] match_w;
    logic              blocked;

    assign match_w = MAX_PT'(match);
    assign blocked = busy | inflight;

    always_comb begin
        res.pick    = first_set(match_w);
        res.accept  = (res.pick.hit && !blocked) ? idx_to_onehot(res.pick.idx) : '0;
        res.err_set = match_w & ~res.accept;
    end

endmodule

// File: rtl/ptc_flags.sv
module ptc_flags #(
    parameter int NPT = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPT-1:0] set_cf,
    input  logic [NPT-1:0] set_err,
    input  logic           clr_en,
    input  logic [NPT-1:0] keep_cf,
    input  logic [NPT-1:0] keep_err,
    output logic [NPT-1:0] cf_q,
    output logic [NPT-1:0] err_q
);

    logic [NPT-1:0] cf_kept;
    logic [NPT-1:0] err_kept;

    assign cf_kept  = clr_en ? (cf_q & keep_cf)   : cf_q;
    assign err_kept = clr_en ? (err_q & keep_err) : err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cf_q  <= '0;
            err_q <= '0;
        end else begin
            cf_q  <= cf_kept | set_cf;
            err_q <= err_kept | set_err;
        end
    end

endmodule

// File: rtl/ptc_readback.sv
module ptc_readback
    import pretrig_pkg::*;
#(
    parameter int NPT = 4
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NPT-1:0]              cf,
    input  logic [NPT-1:0]              err,
    input  logic [NPT-1:0][CNT_W-1:0]   act,
    output logic [REG_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[CF_LSB  +: NPT] = cf;
            rdata[ERR_LSB +: NPT] = err;
        end else begin
            for (int m = 0; m < NPT; m++) begin
                if (addr == ADDR_W'(m + 1)) begin
                    rdata[CNT_W-1:0] = act[m];
                end
            end
        end
    end

endmodule

// File: rtl/pretrig_channel.sv
module pretrig_channel
    import pretrig_pkg::*;
#(
    parameter int NPT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cyc_wrap,
    input  logic [NPT-1:0]    pt_en,
    input  logic              adc_busy,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NPT-1:0]    pt_fire,
    output logic              adc_trig,
    output logic [IDX_W-1:0]  trig_idx
);

    logic [NPT-1:0]            match;
    logic [NPT-1:0][CNT_W-1:0] act;
    logic [NPT-1:0]            cf_q;
    logic [NPT-1:0]            err_q;
    logic                      status_wr;
    arb_t                      arb;

    assign status_wr = reg_wr && (reg_addr == '0);

    for (genvar m = 0; m < NPT; m++) begin : g_slot
        logic sel;
        assign sel = reg_wr && (reg_addr == ADDR_W'(m + 1));
        ptc_delay_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (sel),
            .wr_val   (reg_wdata[CNT_W-1:0]),
            .cyc_wrap (cyc_wrap),
            .cnt_val  (cnt_val),
            .en       (pt_en[m]),
            .match    (match[m]),
            .active   (act[m])
        );
    end

    ptc_arbiter #(.NPT(NPT)) u_arb (
        .match    (match),
        .busy     (adc_busy),
        .inflight (adc_trig),
        .res      (arb)
    );

    ptc_flags #(.NPT(NPT)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_cf   (match),
        .set_err  (arb.err_set[NPT-1:0]),
        .clr_en   (status_wr),
        .keep_cf  (reg_wdata[CF_LSB +: NPT]),
        .keep_err (reg_wdata[ERR_LSB +: NPT]),
        .cf_q     (cf_q),
        .err_q    (err_q)
    );

    ptc_readback #(.NPT(NPT)) u_rd (
        .addr  (reg_addr),
        .cf    (cf_q),
        .err   (err_q),
        .act   (act),
        .rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_fire  <= '0;
            adc_trig <= 1'b0;
            trig_idx <= '0;
        end else begin
            pt_fire  <= match;
            adc_trig <= |arb.accept;
            if (|arb.accept) begin
                trig_idx <= arb.pick.idx;
            end
        end
    end

endmodule

// File: rtl/pretrig_channel_chk.sv
module pretrig_channel_chk
    import pretrig_pkg::*;
#(
    parameter int NPT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_busy,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [NPT-1:0]    pt_fire,
    input logic              adc_trig,
    input logic [IDX_W-1:0]  trig_idx,
    input logic [NPT-1:0]    cf_q,
    input logic [NPT-1:0]    err_q
);

    logic [MAX_PT-1:0] fire_w;
    logic              status_wr;

    assign fire_w    = MAX_PT'(pt_fire);
    assign status_wr = reg_wr && (reg_addr == '0);

    p_trig_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        adc_trig |=> !adc_trig);

    p_trig_idle_r4: assert property (@(posedge clk) disable iff (rst)
        adc_trig |-> !$past(adc_busy));

    p_trig_from_fire_r4: assert property (@(posedge clk) disable iff (rst)
        adc_trig |-> fire_w[trig_idx]);

    p_err_needs_fire_r5: assert property (@(posedge clk) disable iff (rst)
        ((err_q & ~$past(err_q) & ~pt_fire) == '0));

    p_fire_sets_cf_r6: assert property (@(posedge clk) disable iff (rst)
        ((cf_q & pt_fire) == pt_fire));

    p_cf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(status_wr) |-> ((cf_q & $past(cf_q)) == $past(cf_q)));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == '0) |-> (reg_rdata[31:24] == '0 && reg_rdata[15:8] == '0));

endmodule

bind pretrig_channel pretrig_channel_chk #(.NPT(NPT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_busy  (adc_busy),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pt_fire   (pt_fire),
    .adc_trig  (adc_trig),
    .trig_idx  (trig_idx),
    .cf_q      (cf_q),
    .err_q     (err_q)
);

// File: tb/pretrig_channel_tb_top.sv
`timescale 1ns/1ps
module pretrig_channel_tb_top;

    localparam int NPT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_val;
    logic        cyc_wrap;
    logic [3:0]  pt_en;
    logic        adc_busy;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  pt_fire;
    logic        adc_trig;
    logic [2:0]  trig_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] m_shd [4];
    logic [15:0] m_act [4];
    logic [3:0]  m_armed;
    logic [3:0]  m_cf;
    logic [3:0]  m_err;
    logic        m_prev;

    always #2.5 clk = ~clk;

    pretrig_channel #(.NPT(NPT)) dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cyc_wrap(cyc_wrap),
        .pt_en(pt_en), .adc_busy(adc_busy), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pt_fire(pt_fire), .adc_trig(adc_trig), .trig_idx(trig_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) begin
            m_cf  = m_cf & d[19:16];
            m_err = m_err & d[3:0];
        end else if (a <= 4) begin
            m_shd[a-1] = d[15:0];
        end
        m_prev = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wrap();
        @(negedge clk);
        cnt_val = 16'hFFFF; pt_en = '0; cyc_wrap = 1'b1;
        @(negedge clk);
        cyc_wrap = 1'b0;
        for (int m = 0; m < 4; m++) m_act[m] = m_shd[m];
        m_armed = 4'hF;
        m_prev  = 1'b0;
    endtask

    task automatic step(input logic [15:0] c, input logic [3:0] en, input logic busy);
        logic [3:0] mt;
        logic [3:0] acc;
        int pick;
        cnt_val = c; pt_en = en; adc_busy = busy;
        pick = -1;
        for (int m = 0; m < 4; m++)
            mt[m] = m_armed[m] & en[m] & (c == m_act[m]);
        for (int m = 3; m >= 0; m--)
            if (mt[m]) pick = m;
        acc = (pick >= 0 && !busy && !m_prev) ? 4'(1 << pick) : 4'b0;
        @(negedge clk);
        chk("R1 pt_fire", 32'(pt_fire), 32'(mt));
        chk("R4 adc_trig", 32'(adc_trig), 32'(|acc));
        if (|acc) chk("R4 trig_idx", 32'(trig_idx), 32'(pick));
        m_cf    = m_cf | mt;
        m_err   = m_err | (mt & ~acc);
        m_armed = m_armed & ~mt;
        m_prev  = |acc;
    endtask

    task automatic scenario(input logic [15:0] d0, input logic [15:0] d1,
                            input logic [15:0] d2, input logic [15:0] d3,
                            input logic [3:0] en, input int blo, input int bhi,
                            input int passes, input logic [31:0] exp_status);
        logic [31:0] rd;
        reg_write(4'd1, 32'(d0));
        reg_write(4'd2, 32'(d1));
        reg_write(4'd3, 32'(d2));
        reg_write(4'd4, 32'(d3));
        reg_write(4'd0, 32'h0);
        wrap();
        for (int p = 0; p < passes; p++)
            for (int c = 0; c < 24; c++)
                step(16'(c), en, (c >= blo && c <= bhi));
        adc_busy = 1'b0; pt_en = '0;
        reg_read(4'd0, rd);
        chk("R5/R6 status model", rd, {12'h0, m_cf, 12'h0, m_err});
        chk("R5/R6 status hand", rd, exp_status);
    endtask

    initial begin
        logic [31:0] rd;
        rst = 1'b1; cnt_val = 16'hFFFF; cyc_wrap = 0; pt_en = 0; adc_busy = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        for (int m = 0; m < 4; m++) begin m_shd[m] = 0; m_act[m] = 0; end
        m_armed = 4'hF; m_cf = 0; m_err = 0; m_prev = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset values and outputs
        reg_read(4'd0, rd); chk("R9 status reset", rd, 32'h0);
        for (int a = 1; a <= 4; a++) begin
            reg_read(4'(a), rd); chk("R9 delay reset", rd, 32'h0);
        end
        chk("R9 trig reset", 32'(adc_trig), 32'h0);

        // R8: shadow write invisible until wrap, upper bits reserved (R9)
        reg_write(4'd3, 32'hABCD1234);
        reg_read(4'd3, rd); chk("R8 active before wrap", rd, 32'h0);
        wrap();
        reg_read(4'd3, rd); chk("R8 active after wrap", rd, 32'h00001234);
        reg_read(4'd5, rd); chk("R9 slot above NPT", rd, 32'h0);
        for (int a = 9; a < 16; a++) begin
            reg_read(4'(a), rd); chk("R9 unmapped address", rd, 32'h0);
        end

        // R1 R4 R6: distinct delays, ADC idle
        scenario(3, 7, 11, 15, 4'hF, 99, 99, 1, 32'h000F0000);
        // R5: busy window covers slots 1 and 2
        scenario(3, 7, 11, 15, 4'hF, 6, 12, 1, 32'h000F0006);
        // R4 R5: simultaneous match, lowest index wins
        scenario(5, 5, 9, 20, 4'hF, 99, 99, 1, 32'h000F0002);
        // R7: write ones keeps, zeros clear
        reg_write(4'd0, 32'hFFFFFFFF);
        reg_read(4'd0, rd); chk("R7 write one no effect", rd, 32'h000F0002);
        reg_write(4'd0, ~32'h00010002);
        reg_read(4'd0, rd); chk("R7 write zero clears", rd, 32'h000E0000);
        // R4 R5: adjacent delays hit the in-flight trigger
        scenario(5, 6, 12, 13, 4'hF, 99, 99, 1, 32'h000F000A);
        // R2 R3: masked slots, two passes with no wrap
        scenario(4, 8, 12, 16, 4'b1010, 99, 99, 2, 32'h000A0000);
        // R1: zero delays fire at counter zero
        scenario(0, 0, 2, 23, 4'hF, 99, 99, 1, 32'h000F0002);

        // R7: hardware set beats same-cycle software clear
        reg_write(4'd1, 32'd5);
        reg_write(4'd0, 32'h0);
        wrap();
        for (int c = 0; c < 5; c++) step(16'(c), 4'h1, 1'b0);
        @(negedge clk);
        cnt_val = 16'd5; pt_en = 4'h1;
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0; pt_en = 4'h0;
        reg_read(4'd0, rd); chk("R7 set wins over clear", rd, 32'h00010000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule